// File: doc/BRIEF.md
# Tree-Structured Four-Lane Serializer

This block merges four parallel one-bit lanes into a single serial stream that runs at four times the lane rate. A word of four lane bits is taken in once per frame of four fast clock cycles. The lane bits then leave one per cycle, lane 0 first and lane 3 last.

Selection is done by a two-level tree of 2:1 selectors rather than by a shift register. The two first-level selectors pair lane 0 with lane 2 and lane 1 with lane 3. They are steered by the slower of two cascaded divide-by-2 stages. The final selector picks between the two pairs under the faster divider stage. Both divider stages are registers in the fast clock domain, not derived clocks. The slower stage is driven out as a quarter-rate clock, so upstream logic can present each new word in time.

A synchronous reset puts both divider stages into the last slot of a frame. The first fast clock edge after reset therefore captures a word, and the first serial bit is always lane 0.

Top module: `ser4_tree`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, the following cycle shows `ser_out` = 0 and `clk_q` = 1.
- R2: At the first rising `clk` edge with `rst` low after a reset, `ch_in` is captured. In the cycle after that edge, `ser_out` carries `ch_in[0]` of the captured word.
- R3: Within a frame, `ser_out` carries the captured bits in the order `ch_in[0]`, `ch_in[1]`, `ch_in[2]`, `ch_in[3]`, one bit per `clk` cycle.
- R4: `ch_in` is sampled only at the edge that ends the fourth bit slot of a frame. Values on `ch_in` during the other three edges of a frame have no effect on `ser_out`.
- R5: `clk_q` has a period of four `clk` cycles. It is low during bit slots 0 and 1 of each frame and high during slots 2 and 3.
- R6: Every falling transition of `clk_q` coincides with the start of a frame, where `ser_out` carries bit 0 of the captured word.
- R7: Asserting `rst` in the middle of a frame abandons that frame at the next edge and gives the R1 state. After release, the next frame starts with bit 0 of the word captured at the first edge without reset.
- R8: Frames follow each other with no idle cycle. Serial slot 4k+i carries bit i of the k-th captured word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Full-rate bit clock |
| rst | input | 1 | Synchronous reset, active high |
| ch_in | input | 4 | Lane bits, `ch_in[0]` sent first |
| ser_out | output | 1 | Serial output stream, one bit per `clk` cycle |
| clk_q | output | 1 | Quarter-rate clock for upstream timing |

## Verification
The bound checker checks the following on every cycle:
- The fast divider stage toggles every cycle.
- The slow stage steps only after the fast stage has wrapped.
- The frame register is reloaded only at the last slot, and then with the lane values present at that edge.
- The first and last slots of each frame carry the right end of the word.
- The reset state holds.

Only the bench scenarios can show the complete slot ordering for varied words. They also show that values changed mid-frame never leak into the stream, that frames follow each other back to back, and that a reset in mid-frame restarts cleanly with bit 0.

// File: rtl/ser4_pkg.sv
package ser4_pkg;

    // Default lane count of the serializer tree (power of two).
    localparam int unsigned SER_LANES_DEF = 4;

    // Bit offset of tree level `lvl` inside a flat node vector:
    // the leaves sit at 0, and each level halves the node count.
    function automatic int unsigned tree_off(input int unsigned lanes,
                                             input int unsigned lvl);
        return 2 * lanes - 2 * (lanes >> lvl);
    endfunction

endpackage

// File: rtl/ser4_clkdiv.sv
// Chain of divide-by-2 stages kept as enable registers in one clock domain.
// Bit 0 toggles every cycle; bit k toggles when all lower bits are one.
module ser4_clkdiv #(
    parameter int unsigned STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    output logic [STAGES-1:0] div_q,
    output logic              last_slot
);

    typedef struct packed {
        logic [STAGES-1:0] div;
    } div_st_t;

    div_st_t st_d;
    div_st_t st_q;

    always_comb begin
        logic carry;
        st_d  = st_q;
        carry = 1'b1;
        for (int k = 0; k < int'(STAGES); k++) begin
            if (carry) begin
                st_d.div[k] = ~st_q.div[k];
            end
            carry = carry & st_q.div[k];
        end
        if (rst) begin
            // Park in the last slot so the next edge opens a frame.
            st_d.div = '1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign div_q     = st_q.div;
    assign last_slot = &st_q.div;

endmodule

// File: rtl/ser4_frame_reg.sv
// Holds one lane word for a whole frame; reloads only on `load`.
module ser4_frame_reg #(
    parameter int unsigned LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LANES-1:0] word_in,
    output logic [LANES-1:0] word_q
);

    typedef struct packed {
        logic [LANES-1:0] word;
    } frm_st_t;

    frm_st_t st_d;
    frm_st_t st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.word = word_in;
        end
        if (rst) begin
            st_d.word = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign word_q = st_q.word;

endmodule

// File: rtl/ser4_mux_tree.sv
// Binary tree of 2:1 selectors. The first level is steered by the
// most significant select bit, the last level by the least significant,
// so the output equals word[sel].
module ser4_mux_tree
    import ser4_pkg::*;
#(
    parameter int unsigned LANES  = 4,
    parameter int unsigned LEVELS = 2
) (
    input  logic [LANES-1:0]  word,
    input  logic [LEVELS-1:0] sel,
    output logic              bit_out
);

    localparam int unsigned NODES = 2 * LANES - 1;

    logic [NODES-1:0] node;

    assign node[LANES-1:0] = word;

    for (genvar l = 0; l < int'(LEVELS); l++) begin : g_lvl
        localparam int unsigned HALF   = LANES >> (l + 1);
        localparam int unsigned SRC    = tree_off(LANES, l);
        localparam int unsigned DST    = tree_off(LANES, l + 1);
        localparam int unsigned SEL_IX = LEVELS - 1 - l;
        for (genvar j = 0; j < int'(HALF); j++) begin : g_node
            assign node[DST+j] = sel[SEL_IX] ? node[SRC+j+HALF] : node[SRC+j];
        end
    end

    assign bit_out = node[NODES-1];

endmodule

// File: rtl/ser4_tree.sv
module ser4_tree
    import ser4_pkg::*;
#(
    parameter int unsigned LANES = SER_LANES_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] ch_in,
    output logic             ser_out,
    output logic             clk_q
);

    localparam int unsigned LEVELS = $clog2(LANES);

    logic [LEVELS-1:0] div_q;
    logic              last_slot;
    logic [LANES-1:0]  frame_q;

    ser4_clkdiv #(
        .STAGES (LEVELS)
    ) u_div (
        .clk       (clk),
        .rst       (rst),
        .div_q     (div_q),
        .last_slot (last_slot)
    );

    ser4_frame_reg #(
        .LANES (LANES)
    ) u_frame (
        .clk     (clk),
        .rst     (rst),
        .load    (last_slot),
        .word_in (ch_in),
        .word_q  (frame_q)
    );

    ser4_mux_tree #(
        .LANES  (LANES),
        .LEVELS (LEVELS)
    ) u_tree (
        .word    (frame_q),
        .sel     (div_q),
        .bit_out (ser_out)
    );

    // Slowest divider stage doubles as the exported quarter-rate clock.
    assign clk_q = div_q[LEVELS-1];

endmodule

// File: rtl/ser4_tree_chk.sv
module ser4_tree_chk #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned LEVELS = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [LANES-1:0]  ch_in,
    input logic              ser_out,
    input logic              clk_q,
    input logic [LEVELS-1:0] div_q,
    input logic [LANES-1:0]  frame_q
);

    logic seen_q = 1'b0;

    always_ff @(posedge clk) begin
        seen_q <= 1'b1;
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        (seen_q && $past(rst)) |-> (clk_q && !ser_out)); // R1

    AST_WORD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(&div_q)) |-> (frame_q == $past(ch_in))); // R2

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(&div_q)) |-> $stable(frame_q)); // R4

    AST_LAST_SLOT_BIT: assert property (@(posedge clk) disable iff (rst)
        (&div_q) |-> (ser_out == frame_q[LANES-1])); // R3

    AST_FRAME_OPEN_BIT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(clk_q)) |-> (ser_out == frame_q[0])); // R6

    AST_FAST_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (div_q[0] != $past(div_q[0]))); // R5

    if (LEVELS > 1) begin : g_slow
        AST_SLOW_HOLD: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(&div_q[LEVELS-2:0])) |-> $stable(clk_q)); // R5
        AST_SLOW_STEP: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(&div_q[LEVELS-2:0])) |-> (clk_q != $past(clk_q))); // R5
    end

endmodule

bind ser4_tree ser4_tree_chk #(
    .LANES  (LANES),
    .LEVELS (LEVELS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ch_in   (ch_in),
    .ser_out (ser_out),
    .clk_q   (clk_q),
    .div_q   (div_q),
    .frame_q (frame_q)
);

// File: tb/ser4_tree_tb.sv
`timescale 1ns/1ps
module ser4_tree_tb;

    localparam int unsigned LANES = 4;
    localparam int unsigned NW    = 8;
    localparam logic [LANES-1:0] WORDS [NW] = '{
        4'b0001, 4'b0010, 4'b0100, 4'b1000,
        4'b1111, 4'b0000, 4'b1010, 4'b0110
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [LANES-1:0] ch_in = '0;
    logic             ser_out;
    logic             clk_q;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    ser4_tree #(.LANES(LANES)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .ch_in   (ch_in),
        .ser_out (ser_out),
        .clk_q   (clk_q)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        ch_in = WORDS[0];
        rst   = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset ser_out", ser_out, 1'b0);
        chk("R1 reset clk_q", clk_q, 1'b1);
        rst = 1'b0;

        // Table walk: back-to-back frames (R8), junk mid-frame (R4).
        for (int w = 0; w < int'(NW); w++) begin
            for (int s = 0; s < 4; s++) begin
                @(negedge clk);
                if (w == 0) chk("R2 first frame bit", ser_out, WORDS[w][s]);
                else        chk("R3/R8 slot bit", ser_out, WORDS[w][s]);
                if (s == 0) chk("R6 frame opens on clk_q low", clk_q, 1'b0);
                else        chk("R5 clk_q phase", clk_q, (s >= 2));
                if (s == 1) ch_in = ~WORDS[(w + 1) % NW];
                if (s == 3) ch_in = WORDS[(w + 1) % NW];
            end
        end

        // Reset in the middle of a frame (R7).
        @(negedge clk);
        chk("R4 slot0 after junk", ser_out, WORDS[0][0]);
        @(negedge clk);
        chk("R3 slot1", ser_out, WORDS[0][1]);
        rst   = 1'b1;
        ch_in = 4'b1010;
        @(negedge clk);
        chk("R7 mid-frame reset ser_out", ser_out, 1'b0);
        chk("R7 mid-frame reset clk_q", clk_q, 1'b1);
        rst = 1'b0;
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            chk("R7 restart bit", ser_out, logic'((4'b1010 >> s) & 1));
            chk("R5 restart clk_q", clk_q, (s >= 2));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog (all requirements) act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule